// File: doc/BRIEF.md
# Guarded Dual Accumulator Register Unit

This block holds two 36-bit accumulators. Each one is a 32-bit value with four guard bits on top. A 16-bit bus writes the upper half (bits 31..16) or the lower half (bits 15..0) of either accumulator. A separate 4-bit port writes the guard bits directly. A 36-bit arithmetic path (add, subtract, increment, negate, round) writes its full result, guard bits included, back into a chosen accumulator. Any growth past 32 bits therefore stays visible in the guard bits.

Two per-accumulator controls set how the block behaves. One decides whether a data-move write to the upper half also wipes the lower half. The other decides whether values leaving the block are clamped when the 36-bit contents do not fit in 32 bits. Clamping changes only the outgoing copy; the stored value is never modified by a read. A read port returns the selected half of that outgoing copy, and the full 32-bit copy and the guard bits are also available.

Top module: `gacc_unit`

## Requirements
- R1: After reset both accumulators hold zero in all 36 bits, both `ovf` bits are 0 and `err` is 0.
- R2: A bus write with `bus_sel_hi`=0 replaces bits 15..0 of the selected accumulator and leaves bits 35..16 unchanged.
- R3: A bus write with `bus_sel_hi`=1 loads bits 31..16 from `bus_wdata` and copies `bus_wdata[15]` into bits 35..32.
- R4: On an upper-half write with `bus_move`=1, bits 15..0 are cleared when `hold_low[n]`=0 and kept when `hold_low[n]`=1. With `bus_move`=0 they are always kept.
- R5: When `ar_en`=1, accumulator `ar_dst` receives a 36-bit result chosen by `ar_op`. The codes are: 0 = dst+other, 1 = dst-other, 2 = dst+1, 3 = -dst, 4 = (dst+0x8000) with bits 15..0 cleared. Codes 5..7 write dst back unchanged. "Other" is the accumulator that is not `ar_dst`. All results are taken modulo 2^36.
- R6: `ovf[n]` is 1 exactly when bits 35..31 of accumulator n are neither all 0 nor all 1.
- R7: `xfer_out` equals bits 31..0 of the `rd_sel_acc` accumulator when that accumulator has no overflow, or when `sat_dis[n]`=1.
- R8: When `sat_dis[n]`=0 and overflow exists, `xfer_out` is 0x80000000 if bit 35 is 1 and 0x7FFFFFFF if it is 0. The stored value stays as it was.
- R9: `rd_data` is `xfer_out[31:16]` when `rd_sel_hi`=1 and `xfer_out[15:0]` when it is 0. `guard_rd` shows bits 35..32 of the `rd_sel_acc` accumulator. `gw_we` loads `gw_data` into bits 35..32 of accumulator `gw_sel`, unless an arithmetic or bus write targets that accumulator in the same cycle; in that case the guard write is dropped.
- R10: If an arithmetic write and a bus write target the same accumulator in one cycle, the arithmetic result is stored and `err` is 1 in that cycle. Writes to different accumulators both take effect, and `err` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Bus write enable |
| bus_sel_acc | input | 1 | Bus write target accumulator |
| bus_sel_hi | input | 1 | 1 = upper half, 0 = lower half |
| bus_move | input | 1 | Write is a data move (may clear the lower half) |
| bus_wdata | input | 16 | Bus write data |
| hold_low | input | 2 | Per accumulator: 1 = keep lower half on a move write to the upper half |
| sat_dis | input | 2 | Per accumulator: 1 = no clamping on transfer out |
| gw_we | input | 1 | Guard-bit write enable |
| gw_sel | input | 1 | Guard-bit write target |
| gw_data | input | 4 | Guard-bit write data |
| ar_en | input | 1 | Arithmetic write-back enable |
| ar_dst | input | 1 | Arithmetic destination accumulator |
| ar_op | input | 3 | Arithmetic operation code |
| rd_sel_acc | input | 1 | Read accumulator select |
| rd_sel_hi | input | 1 | Read half select |
| rd_data | output | 16 | Selected half of the outgoing value |
| xfer_out | output | 32 | Outgoing 32-bit value of the selected accumulator |
| guard_rd | output | 4 | Guard bits of the selected accumulator |
| ovf | output | 2 | Per-accumulator overflow flag |
| err | output | 1 | Same-cycle arithmetic/bus write collision |

## Verification
The properties take every input as a known 2-state value. They also assume that `hold_low` and `bus_move` are valid in the same cycle as the write they qualify, because the clear decision is sampled at that clock edge. The bench meets this by changing inputs only one time unit after a rising edge. It keeps all enables low between operations and loads each 36-bit value in three separate cycles: upper half, lower half, guard bits. The only cycles in which writes overlap are the deliberate collision and dropped-guard cases.

// File: rtl/gacc_pkg.sv
`timescale 1ns/1ps
package gacc_pkg;
    typedef enum logic [2:0] {
        AOP_ADD = 3'd0,
        AOP_SUB = 3'd1,
        AOP_INC = 3'd2,
        AOP_NEG = 3'd3,
        AOP_RND = 3'd4
    } aop_e;
endpackage

// File: rtl/gacc_reg.sv
`timescale 1ns/1ps
// One guarded accumulator with write priority: arithmetic, then bus, then guard port.
module gacc_reg #(
    parameter  int HALF_W  = 16,
    parameter  int GUARD_W = 4,
    localparam int VAL_W   = 2 * HALF_W,
    localparam int ACC_W   = VAL_W + GUARD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ar_we,
    input  logic [ACC_W-1:0]   ar_val,
    input  logic               bus_we,
    input  logic               bus_hi,
    input  logic               bus_clr,
    input  logic [HALF_W-1:0]  bus_d,
    input  logic               gw_we,
    input  logic [GUARD_W-1:0] gw_d,
    output logic [ACC_W-1:0]   q
);
    logic [ACC_W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (ar_we) begin
            nxt = ar_val;
        end else if (bus_we) begin
            if (bus_hi) begin
                nxt[VAL_W-1:HALF_W] = bus_d;
                nxt[ACC_W-1:VAL_W]  = {GUARD_W{bus_d[HALF_W-1]}};
                if (bus_clr) begin
                    nxt[HALF_W-1:0] = '0;
                end
            end else begin
                nxt[HALF_W-1:0] = bus_d;
            end
        end else if (gw_we) begin
            nxt[ACC_W-1:VAL_W] = gw_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end
endmodule

// File: rtl/gacc_alu.sv
`timescale 1ns/1ps
// Full-width arithmetic on guarded values.
module gacc_alu
    import gacc_pkg::*;
#(
    parameter  int HALF_W  = 16,
    parameter  int GUARD_W = 4,
    localparam int VAL_W   = 2 * HALF_W,
    localparam int ACC_W   = VAL_W + GUARD_W
) (
    input  logic [ACC_W-1:0] dst_v,
    input  logic [ACC_W-1:0] oth_v,
    input  logic [2:0]       op,
    output logic [ACC_W-1:0] res
);
    localparam logic [ACC_W-1:0] ONE   = ACC_W'(1);
    localparam logic [ACC_W-1:0] HALFB = ACC_W'(1) << (HALF_W - 1);

    logic [ACC_W-1:0] rnd_sum;
    assign rnd_sum = dst_v + HALFB;

    always_comb begin
        case (aop_e'(op))
            AOP_ADD: res = dst_v + oth_v;
            AOP_SUB: res = dst_v - oth_v;
            AOP_INC: res = dst_v + ONE;
            AOP_NEG: res = '0 - dst_v;
            AOP_RND: res = {rnd_sum[ACC_W-1:HALF_W], {HALF_W{1'b0}}};
            default: res = dst_v;
        endcase
    end
endmodule

// File: rtl/gacc_sat.sv
`timescale 1ns/1ps
// Overflow detection and clamped transfer copy of one accumulator.
module gacc_sat #(
    parameter  int HALF_W  = 16,
    parameter  int GUARD_W = 4,
    localparam int VAL_W   = 2 * HALF_W,
    localparam int ACC_W   = VAL_W + GUARD_W
) (
    input  logic [ACC_W-1:0] v,
    input  logic             dis,
    output logic [VAL_W-1:0] xfer,
    output logic             ovf
);
    logic [GUARD_W:0] top;
    assign top = v[ACC_W-1:VAL_W-1];
    assign ovf = !((&top) || !(|top));

    always_comb begin
        if (ovf && !dis) begin
            xfer = v[ACC_W-1] ? {1'b1, {(VAL_W-1){1'b0}}}
                              : {1'b0, {(VAL_W-1){1'b1}}};
        end else begin
            xfer = v[VAL_W-1:0];
        end
    end
endmodule

// File: rtl/gacc_unit.sv
`timescale 1ns/1ps
module gacc_unit #(
    parameter  int HALF_W  = 16,
    parameter  int GUARD_W = 4,
    localparam int VAL_W   = 2 * HALF_W,
    localparam int ACC_W   = VAL_W + GUARD_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic               bus_sel_acc,
    input  logic               bus_sel_hi,
    input  logic               bus_move,
    input  logic [HALF_W-1:0]  bus_wdata,
    input  logic [1:0]         hold_low,
    input  logic [1:0]         sat_dis,
    input  logic               gw_we,
    input  logic               gw_sel,
    input  logic [GUARD_W-1:0] gw_data,
    input  logic               ar_en,
    input  logic               ar_dst,
    input  logic [2:0]         ar_op,
    input  logic               rd_sel_acc,
    input  logic               rd_sel_hi,
    output logic [HALF_W-1:0]  rd_data,
    output logic [VAL_W-1:0]   xfer_out,
    output logic [GUARD_W-1:0] guard_rd,
    output logic [1:0]         ovf,
    output logic               err
);
    logic [1:0][ACC_W-1:0] acc_q;
    logic [1:0][VAL_W-1:0] xfer_v;
    logic [ACC_W-1:0]      alu_res;

    gacc_alu #(.HALF_W(HALF_W), .GUARD_W(GUARD_W)) u_alu (
        .dst_v (acc_q[ar_dst]),
        .oth_v (acc_q[~ar_dst]),
        .op    (ar_op),
        .res   (alu_res)
    );

    for (genvar i = 0; i < 2; i++) begin : g_acc
        gacc_reg #(.HALF_W(HALF_W), .GUARD_W(GUARD_W)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .ar_we  (ar_en && (ar_dst == 1'(i))),
            .ar_val (alu_res),
            .bus_we (bus_we && (bus_sel_acc == 1'(i))),
            .bus_hi (bus_sel_hi),
            .bus_clr(bus_move && !hold_low[i]),
            .bus_d  (bus_wdata),
            .gw_we  (gw_we && (gw_sel == 1'(i))),
            .gw_d   (gw_data),
            .q      (acc_q[i])
        );

        gacc_sat #(.HALF_W(HALF_W), .GUARD_W(GUARD_W)) u_sat (
            .v   (acc_q[i]),
            .dis (sat_dis[i]),
            .xfer(xfer_v[i]),
            .ovf (ovf[i])
        );
    end

    assign xfer_out = xfer_v[rd_sel_acc];
    assign rd_data  = rd_sel_hi ? xfer_out[VAL_W-1:HALF_W] : xfer_out[HALF_W-1:0];
    assign guard_rd = acc_q[rd_sel_acc][ACC_W-1:VAL_W];
    assign err      = ar_en && bus_we && (ar_dst == bus_sel_acc);
endmodule

// File: rtl/gacc_chk.sv
`timescale 1ns/1ps
module gacc_chk #(
    parameter  int HALF_W  = 16,
    parameter  int GUARD_W = 4,
    localparam int VAL_W   = 2 * HALF_W,
    localparam int ACC_W   = VAL_W + GUARD_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_we,
    input logic                  bus_sel_acc,
    input logic                  bus_sel_hi,
    input logic                  bus_move,
    input logic [1:0]            hold_low,
    input logic [1:0]            sat_dis,
    input logic                  ar_en,
    input logic                  ar_dst,
    input logic                  rd_sel_acc,
    input logic [VAL_W-1:0]      xfer_out,
    input logic [1:0]            ovf,
    input logic                  err,
    input logic [1:0][ACC_W-1:0] acc_q
);
    logic clean_bus;
    assign clean_bus = bus_we && !(ar_en && (ar_dst == bus_sel_acc));

    // R2
    lower_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clean_bus && !bus_sel_hi |=>
        acc_q[$past(bus_sel_acc)][ACC_W-1:HALF_W] == $past(acc_q[bus_sel_acc][ACC_W-1:HALF_W]));

    // R3
    sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clean_bus && bus_sel_hi |=>
        acc_q[$past(bus_sel_acc)][ACC_W-1:VAL_W] == {GUARD_W{acc_q[$past(bus_sel_acc)][VAL_W-1]}});

    // R4
    clear_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clean_bus && bus_sel_hi && bus_move && !hold_low[bus_sel_acc] |=>
        acc_q[$past(bus_sel_acc)][HALF_W-1:0] == '0);

    // R6
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf[0] |-> (acc_q[0][ACC_W-1:VAL_W-1] != '0) && (acc_q[0][ACC_W-1:VAL_W-1] != '1));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf[rd_sel_acc] || sat_dis[rd_sel_acc]) |-> xfer_out == acc_q[rd_sel_acc][VAL_W-1:0]);

    // R8
    sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[rd_sel_acc] && !sat_dis[rd_sel_acc]) |->
        (xfer_out[VAL_W-1] == acc_q[rd_sel_acc][ACC_W-1]) &&
        (xfer_out[VAL_W-2:0] == {(VAL_W-1){!acc_q[rd_sel_acc][ACC_W-1]}}));

    // R10
    collide_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ar_en && bus_we && (ar_dst == bus_sel_acc) |-> err);
endmodule

bind gacc_unit gacc_chk #(.HALF_W(HALF_W), .GUARD_W(GUARD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_sel_acc(bus_sel_acc),
    .bus_sel_hi (bus_sel_hi),
    .bus_move   (bus_move),
    .hold_low   (hold_low),
    .sat_dis    (sat_dis),
    .ar_en      (ar_en),
    .ar_dst     (ar_dst),
    .rd_sel_acc (rd_sel_acc),
    .xfer_out   (xfer_out),
    .ovf        (ovf),
    .err        (err),
    .acc_q      (acc_q)
);

// File: tb/gacc_unit_bench.sv
`timescale 1ns/1ps
module gacc_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 0, bus_sel_acc = 0, bus_sel_hi = 0, bus_move = 0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  hold_low = '0, sat_dis = '0;
    logic        gw_we = 0, gw_sel = 0;
    logic [3:0]  gw_data = '0;
    logic        ar_en = 0, ar_dst = 0;
    logic [2:0]  ar_op = '0;
    logic        rd_sel_acc = 0, rd_sel_hi = 0;
    logic [15:0] rd_data;
    logic [31:0] xfer_out;
    logic [3:0]  guard_rd;
    logic [1:0]  ovf;
    logic        err;

    int n_tests = 0;
    int n_fail  = 0;
    logic [35:0] m [2];

    always #2.5 clk = ~clk;

    gacc_unit u_gacc_unit (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_sel_acc(bus_sel_acc),
        .bus_sel_hi(bus_sel_hi), .bus_move(bus_move), .bus_wdata(bus_wdata),
        .hold_low(hold_low), .sat_dis(sat_dis), .gw_we(gw_we), .gw_sel(gw_sel),
        .gw_data(gw_data), .ar_en(ar_en), .ar_dst(ar_dst), .ar_op(ar_op),
        .rd_sel_acc(rd_sel_acc), .rd_sel_hi(rd_sel_hi), .rd_data(rd_data),
        .xfer_out(xfer_out), .guard_rd(guard_rd), .ovf(ovf), .err(err)
    );

    task automatic check(string req, logic [35:0] act, logic [35:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_xfer(logic [35:0] v, logic dis);
        logic o;
        o = !((v[35:31] == 5'h00) || (v[35:31] == 5'h1f));
        if (o && !dis) return v[35] ? 32'h8000_0000 : 32'h7FFF_FFFF;
        return v[31:0];
    endfunction

    function automatic logic [35:0] exp_arith(logic [35:0] d, logic [35:0] o, logic [2:0] op);
        logic [35:0] s;
        case (op)
            3'd0: return d + o;
            3'd1: return d - o;
            3'd2: return d + 36'd1;
            3'd3: return 36'd0 - d;
            3'd4: begin s = d + 36'h8000; return {s[35:16], 16'h0}; end
            default: return d;
        endcase
    endfunction

    function automatic logic [35:0] seed(int i);
        case (i)
            0: return 36'h0_0000_0000;
            1: return 36'h0_0000_0001;
            2: return 36'h0_7FFF_FFFF;
            3: return 36'hF_8000_0000;
            4: return 36'hF_FFFF_FFFF;
            5: return 36'h0_8000_7FFF;
            6: return 36'h8_0000_0000;
            default: return 36'h1_2345_8000;
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
        bus_we = 0; gw_we = 0; ar_en = 0; bus_move = 0;
    endtask

    task automatic bus_wr(logic a, logic hi, logic mv, logic [15:0] d);
        bus_we = 1; bus_sel_acc = a; bus_sel_hi = hi; bus_move = mv; bus_wdata = d;
        if (hi) m[a] = {{4{d[15]}}, d, (mv && !hold_low[a]) ? 16'h0 : m[a][15:0]};
        else    m[a][15:0] = d;
        step();
    endtask

    task automatic gd_wr(logic a, logic [3:0] g);
        gw_we = 1; gw_sel = a; gw_data = g;
        m[a][35:32] = g;
        step();
    endtask

    task automatic load(logic a, logic [35:0] v);
        bus_wr(a, 1'b1, 1'b0, v[31:16]);
        bus_wr(a, 1'b0, 1'b0, v[15:0]);
        gd_wr(a, v[35:32]);
    endtask

    task automatic arith(logic d, logic [2:0] op);
        ar_en = 1; ar_dst = d; ar_op = op;
        m[d] = exp_arith(m[d], m[~d], op);
        step();
    endtask

    task automatic chk_acc(logic a, string req);
        logic [31:0] x;
        logic        o;
        x = exp_xfer(m[a], sat_dis[a]);
        o = !((m[a][35:31] == 5'h00) || (m[a][35:31] == 5'h1f));
        rd_sel_acc = a; rd_sel_hi = 1; #0.2;
        check({req, " R9 rd_data high"}, 36'(rd_data), 36'(x[31:16]));
        rd_sel_hi = 0; #0.2;
        check({req, " R9 rd_data low"}, 36'(rd_data), 36'(x[15:0]));
        check({req, " R7/R8 xfer_out"}, 36'(xfer_out), 36'(x));
        check({req, " R9 guard_rd"}, 36'(guard_rd), 36'(m[a][35:32]));
        check({req, " R6 ovf"}, 36'(ovf[a]), 36'(o));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        m[0] = '0; m[1] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        chk_acc(1'b0, "R1");
        chk_acc(1'b1, "R1");
        check("R1 err", 36'(err), 36'd0);

        // R2 / R3 half writes, raw view
        sat_dis = 2'b11;
        for (int a = 0; a < 2; a++) begin
            load(1'(a), 36'h3_1234_5678);
            bus_wr(1'(a), 1'b0, 1'b1, 16'hBEEF);
            chk_acc(1'(a), "R2 lower write");
            bus_wr(1'(a), 1'b1, 1'b0, 16'h8001);
            chk_acc(1'(a), "R3 upper negative");
            bus_wr(1'(a), 1'b1, 1'b0, 16'h7001);
            chk_acc(1'(a), "R3 upper positive");
        end

        // R4 clear/keep sweep
        for (int a = 0; a < 2; a++)
            for (int h = 0; h < 2; h++)
                for (int mv = 0; mv < 2; mv++) begin
                    hold_low = 2'(h) << a;
                    load(1'(a), 36'h0_1234_5678);
                    bus_wr(1'(a), 1'b1, 1'(mv), 16'h9ABC);
                    chk_acc(1'(a), "R4 move clear");
                end
        hold_low = '0;

        // R5 arithmetic sweep
        for (int d = 0; d < 2; d++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int op = 0; op < 8; op++) begin
                        if (op < 5 || (i == j && op == 5)) begin
                            load(1'(d), seed(i));
                            load(1'(1 - d), seed(j));
                            arith(1'(d), 3'(op));
                            chk_acc(1'(d), "R5 arith dst");
                            chk_acc(1'(1 - d), "R5 arith other");
                        end
                    end

        // R6 / R7 / R8 saturation sweep
        for (int a = 0; a < 2; a++)
            for (int g = 0; g < 16; g++)
                for (int b = 0; b < 2; b++) begin
                    load(1'(a), {4'(g), 1'(b), 31'h1234_5678});
                    sat_dis = 2'b00;
                    chk_acc(1'(a), "R8 sat on");
                    sat_dis = 2'b11;
                    chk_acc(1'(a), "R7 sat off, R8 store kept");
                end

        // R10 collision: arithmetic wins, err high
        sat_dis = 2'b11;
        load(1'b0, 36'd5);
        load(1'b1, 36'd3);
        ar_en = 1; ar_dst = 0; ar_op = 3'd0;
        bus_we = 1; bus_sel_acc = 0; bus_sel_hi = 1; bus_wdata = 16'hAAAA;
        #0.2;
        check("R10 err collision", 36'(err), 36'd1);
        m[0] = 36'd8;
        step();
        chk_acc(1'b0, "R10 arith wins");
        check("R10 err cleared", 36'(err), 36'd0);

        // R10 different targets: both apply, no err
        ar_en = 1; ar_dst = 0; ar_op = 3'd2;
        bus_we = 1; bus_sel_acc = 1; bus_sel_hi = 0; bus_wdata = 16'h0042;
        #0.2;
        check("R10 err no collision", 36'(err), 36'd0);
        m[0] = 36'd9; m[1][15:0] = 16'h0042;
        step();
        chk_acc(1'b0, "R10 split arith");
        chk_acc(1'b1, "R10 split bus");

        // R9 guard write dropped when bus targets same accumulator
        gw_we = 1; gw_sel = 1; gw_data = 4'h6;
        bus_we = 1; bus_sel_acc = 1; bus_sel_hi = 0; bus_wdata = 16'h1111;
        m[1][15:0] = 16'h1111;
        step();
        chk_acc(1'b1, "R9 guard dropped");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule